// File: doc/BRIEF.md
# Stack and Subroutine Sequencer

This block owns an 8-bit stack pointer and carries out the byte-by-byte memory traffic behind six control-flow operations of a small 8-bit processor. These are subroutine call, subroutine return, interrupt return, software break, single-register push and single-register pull. The caller presents a command code together with the current program counter, a target address, the status byte and a data byte. The sequencer then drives a synchronous single-port memory, one byte per cycle. When the work is finished it pulses `done` and holds the new program counter, the new status byte or the pulled byte on its outputs.

The stack lives in the second 256-byte page of the address space and grows toward lower addresses. Opcode fetch, operand fetch and vector fetch belong to the caller, which supplies the jump target directly.

The memory has one cycle of read latency. The address presented in one cycle returns its byte on `mem_rdata` in the next cycle. A write is taken at the clock edge that closes the cycle in which `mem_we` is high.

Top module: `stk_seq`

## Requirements
- R1: Every stack byte address is 0x0100 plus the stack pointer. A push writes at 0x0100+SP and then lowers SP by one. A pull first raises SP by one and then reads at the new 0x0100+SP. SP wraps modulo 256 in both directions.
- R2: After reset, SP is 0xFD, `done` and `busy` are low, and `pc_out`, `status_out` and `pull_data` are zero.
- R3: Command 1 (call) pushes the high byte of PC-1 and then its low byte. It then returns the target address on `pc_out`.
- R4: Command 2 (return) pops the low byte and then the high byte. It returns the 16-bit popped value plus one, modulo 65536, on `pc_out`.
- R5: Command 4 (break) pushes the high byte of PC+2, then its low byte, then the status byte with bits 5 and 4 set. It returns the target on `pc_out` and the input status with bits 5, 4 and 2 set on `status_out`.
- R6: Command 3 (interrupt return) pops the status byte, then the low PC byte, then the high PC byte. It returns the status with bit 5 forced to 1 and the PC with no increment.
- R7: Command 5 (push) writes `push_data` to the stack. Command 6 (pull) returns the popped byte on `pull_data`.
- R8: `done` is high for exactly one cycle. Count the negative edges after the one at which the command is driven. `done` is first seen k+1 edges later for a command that writes k bytes (push 2, call 3, break 4). It is first seen k+2 edges later for a command that reads k bytes (pull 3, return 4, interrupt return 5).
- R9: A command presented while a sequence is running is ignored. It causes no memory write, no SP change and no extra `done`.
- R10: Command codes 0 and 7 are never accepted. They leave `busy`, `done` and SP unchanged.
- R11: `mem_we` is high only in the write steps of an accepted command and is low whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, taken only while idle |
| cmd | input | 3 | Command code (1 call, 2 return, 3 interrupt return, 4 break, 5 push, 6 pull) |
| pc_in | input | 16 | Current program counter |
| tgt_in | input | 16 | Jump target for call and break |
| status_in | input | 8 | Status byte for break |
| push_data | input | 8 | Byte written by a push |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 8 | Memory read data, valid one cycle after the address |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | High while a sequence runs |
| pc_out | output | 16 | New program counter |
| status_out | output | 8 | New status byte |
| pull_data | output | 8 | Byte returned by a pull |
| sp_out | output | 8 | Current stack pointer |

## Verification
The bench examines byte order on the stack. A call followed by a return would round-trip even if both halves swapped their order, so the individual stack bytes are read back from the bench's memory model. The interrupt return is fed a hand-built frame with three distinct bytes, which exposes a design that pops in the wrong order or adds an increment.

Return from PC 0x0000 must wrap to 0x0000 through 0xFFFF. Three pulls from 0xFD and a push at 0x00 must cross the page boundary without leaving page one.

Stray commands are driven mid-sequence, and the reserved codes are driven while idle. A design that accepts either would show an extra write, a changed SP or a second `done`.

// File: rtl/stk_seq_pkg.sv
package stk_seq_pkg;

    localparam int ADDR_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        CMD_NONE = 3'd0,
        CMD_CALL = 3'd1,
        CMD_RET  = 3'd2,
        CMD_IRET = 3'd3,
        CMD_BRK  = 3'd4,
        CMD_PUSH = 3'd5,
        CMD_PULL = 3'd6,
        CMD_RSVD = 3'd7
    } stk_cmd_e;

    // status bits touched by the sequencer
    localparam logic [BYTE_W-1:0] ST_ONE  = 8'h20; // always-one bit
    localparam logic [BYTE_W-1:0] ST_BRKF = 8'h10; // break marker
    localparam logic [BYTE_W-1:0] ST_IDIS = 8'h04; // interrupt disable

    function automatic logic cmd_legal(input logic [2:0] c);
        return (c != CMD_NONE) && (c != CMD_RSVD);
    endfunction

endpackage

// File: rtl/stk_ptr.sv
module stk_ptr
    import stk_seq_pkg::*;
#(
    parameter int unsigned           STACK_PAGE = 1,
    parameter logic [BYTE_W-1:0]     SP_RESET   = 8'hFD
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push_en,
    input  logic                 pull_en,
    output logic [BYTE_W-1:0]    sp_q,
    output logic [ADDR_W-1:0]    wr_addr,
    output logic [ADDR_W-1:0]    rd_addr
);
    localparam int HI_W = ADDR_W - BYTE_W;
    localparam logic [HI_W-1:0]   PAGE_V = HI_W'(STACK_PAGE);
    localparam logic [BYTE_W-1:0] ONE    = BYTE_W'(1);

    logic [BYTE_W-1:0] sp_d;
    logic [BYTE_W-1:0] sp_up;

    always_comb begin
        sp_up = sp_q + ONE;
        sp_d  = sp_q;
        if (push_en)      sp_d = sp_q - ONE;
        else if (pull_en) sp_d = sp_up;
        wr_addr = {PAGE_V, sp_q};
        rd_addr = {PAGE_V, sp_up};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sp_q <= SP_RESET;
        else        sp_q <= sp_d;
    end

endmodule

// File: rtl/stk_seq_fsm.sv
module stk_seq_fsm
    import stk_seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [2:0]           cmd,
    input  logic [ADDR_W-1:0]    pc_in,
    input  logic [ADDR_W-1:0]    tgt_in,
    input  logic [BYTE_W-1:0]    status_in,
    input  logic [BYTE_W-1:0]    push_data,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [ADDR_W-1:0]    rd_addr,
    input  logic [BYTE_W-1:0]    mem_rdata,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [BYTE_W-1:0]    mem_wdata,
    output logic                 mem_we,
    output logic                 push_en,
    output logic                 pull_en,
    output logic                 busy,
    output logic                 done,
    output logic [ADDR_W-1:0]    pc_out,
    output logic [BYTE_W-1:0]    status_out,
    output logic [BYTE_W-1:0]    pull_data
);
    localparam int STEP_W = 2;

    typedef struct packed {
        logic                busy;
        stk_cmd_e            cmd;
        logic [STEP_W-1:0]   step;
        logic [ADDR_W-1:0]   ret_a;   // return address to push
        logic [ADDR_W-1:0]   tgt;
        logic [BYTE_W-1:0]   wbyte;   // single byte to push
        logic [BYTE_W-1:0]   cap0;    // first popped byte
        logic [BYTE_W-1:0]   cap1;    // second popped byte
        logic                done;
        logic [ADDR_W-1:0]   pc_o;
        logic [BYTE_W-1:0]   st_o;
        logic [BYTE_W-1:0]   pull_o;
    } seq_t;

    seq_t d, q;
    logic fin;

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        fin       = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = wr_addr;
        mem_wdata = '0;
        push_en   = 1'b0;
        pull_en   = 1'b0;

        if (!q.busy) begin
            if (cmd_valid && cmd_legal(cmd)) begin
                d.busy  = 1'b1;
                d.cmd   = stk_cmd_e'(cmd);
                d.step  = '0;
                d.tgt   = tgt_in;
                d.ret_a = (cmd == CMD_CALL) ? pc_in - ADDR_W'(1)
                                            : pc_in + ADDR_W'(2);
                d.wbyte = (cmd == CMD_BRK) ? (status_in | ST_ONE | ST_BRKF)
                                           : push_data;
            end
        end else begin
            unique case (q.cmd)
                CMD_CALL, CMD_BRK: begin
                    mem_we  = 1'b1;
                    push_en = 1'b1;
                    case (q.step)
                        2'd0:    mem_wdata = q.ret_a[ADDR_W-1:BYTE_W];
                        2'd1:    mem_wdata = q.ret_a[BYTE_W-1:0];
                        default: mem_wdata = q.wbyte;
                    endcase
                    if ((q.cmd == CMD_CALL) ? (q.step == 2'd1) : (q.step == 2'd2)) begin
                        fin    = 1'b1;
                        d.pc_o = q.tgt;
                        if (q.cmd == CMD_BRK) d.st_o = q.wbyte | ST_IDIS;
                    end
                end
                CMD_PUSH: begin
                    mem_we    = 1'b1;
                    push_en   = 1'b1;
                    mem_wdata = q.wbyte;
                    fin       = 1'b1;
                end
                CMD_PULL: begin
                    if (q.step == 2'd0) begin
                        mem_addr = rd_addr;
                        pull_en  = 1'b1;
                    end else begin
                        d.pull_o = mem_rdata;
                        fin      = 1'b1;
                    end
                end
                CMD_RET: begin
                    case (q.step)
                        2'd0: begin
                            mem_addr = rd_addr;
                            pull_en  = 1'b1;
                        end
                        2'd1: begin
                            mem_addr = rd_addr;
                            pull_en  = 1'b1;
                            d.cap0   = mem_rdata;
                        end
                        default: begin
                            d.pc_o = {mem_rdata, q.cap0} + ADDR_W'(1);
                            fin    = 1'b1;
                        end
                    endcase
                end
                CMD_IRET: begin
                    case (q.step)
                        2'd0: begin
                            mem_addr = rd_addr;
                            pull_en  = 1'b1;
                        end
                        2'd1: begin
                            mem_addr = rd_addr;
                            pull_en  = 1'b1;
                            d.cap0   = mem_rdata;
                        end
                        2'd2: begin
                            mem_addr = rd_addr;
                            pull_en  = 1'b1;
                            d.cap1   = mem_rdata;
                        end
                        default: begin
                            d.st_o = q.cap0 | ST_ONE;
                            d.pc_o = {mem_rdata, q.cap1};
                            fin    = 1'b1;
                        end
                    endcase
                end
                default: fin = 1'b1;
            endcase

            if (fin) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end else begin
                d.step = q.step + STEP_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy       = q.busy;
    assign done       = q.done;
    assign pc_out     = q.pc_o;
    assign status_out = q.st_o;
    assign pull_data  = q.pull_o;

endmodule

// File: rtl/stk_seq.sv
module stk_seq
    import stk_seq_pkg::*;
#(
    parameter int unsigned        STACK_PAGE = 1,
    parameter logic [BYTE_W-1:0]  SP_RESET   = 8'hFD
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [2:0]           cmd,
    input  logic [ADDR_W-1:0]    pc_in,
    input  logic [ADDR_W-1:0]    tgt_in,
    input  logic [BYTE_W-1:0]    status_in,
    input  logic [BYTE_W-1:0]    push_data,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [BYTE_W-1:0]    mem_wdata,
    output logic                 mem_we,
    input  logic [BYTE_W-1:0]    mem_rdata,
    output logic                 done,
    output logic                 busy,
    output logic [ADDR_W-1:0]    pc_out,
    output logic [BYTE_W-1:0]    status_out,
    output logic [BYTE_W-1:0]    pull_data,
    output logic [BYTE_W-1:0]    sp_out
);
    logic              push_en;
    logic              pull_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr;

    stk_ptr #(
        .STACK_PAGE (STACK_PAGE),
        .SP_RESET   (SP_RESET)
    ) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_en (push_en),
        .pull_en (pull_en),
        .sp_q    (sp_out),
        .wr_addr (wr_addr),
        .rd_addr (rd_addr)
    );

    stk_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd        (cmd),
        .pc_in      (pc_in),
        .tgt_in     (tgt_in),
        .status_in  (status_in),
        .push_data  (push_data),
        .wr_addr    (wr_addr),
        .rd_addr    (rd_addr),
        .mem_rdata  (mem_rdata),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_we     (mem_we),
        .push_en    (push_en),
        .pull_en    (pull_en),
        .busy       (busy),
        .done       (done),
        .pc_out     (pc_out),
        .status_out (status_out),
        .pull_data  (pull_data)
    );

endmodule

// File: rtl/stk_seq_chk.sv
module stk_seq_chk
    import stk_seq_pkg::*;
#(
    parameter int unsigned        STACK_PAGE = 1,
    parameter logic [BYTE_W-1:0]  SP_RESET   = 8'hFD
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 mem_we,
    input logic [ADDR_W-1:0]    mem_addr,
    input logic [BYTE_W-1:0]    sp,
    input logic                 done,
    input logic                 busy
);
    localparam int HI_W = ADDR_W - BYTE_W;
    localparam logic [HI_W-1:0] PAGE_V = HI_W'(STACK_PAGE);

    p_write_page_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[ADDR_W-1:BYTE_W] == PAGE_V && mem_addr[BYTE_W-1:0] == sp));

    p_write_dec_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (sp == $past(sp) - BYTE_W'(1)));

    p_reset_sp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sp == SP_RESET && !done && !busy));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_we);

    p_idle_sp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done) |=> (busy || sp == $past(sp)));

endmodule

bind stk_seq stk_seq_chk #(
    .STACK_PAGE (STACK_PAGE),
    .SP_RESET   (SP_RESET)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .sp       (sp_out),
    .done     (done),
    .busy     (busy)
);

// File: tb/stk_seq_bench.sv
module stk_seq_bench;
    import stk_seq_pkg::*;

    localparam time CLK_P = 20ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd = 3'd0;
    logic [15:0] pc_in = '0, tgt_in = '0;
    logic [7:0]  status_in = '0, push_data = '0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        mem_we, done, busy;
    logic [15:0] pc_out;
    logic [7:0]  status_out, pull_data, sp_out;

    int checks = 0;
    int errors = 0;
    int page_err = 0;
    int done_cnt = 0;
    int we_cnt = 0;

    always #(CLK_P/2) clk = ~clk;

    stk_seq u_stk_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
        .pc_in(pc_in), .tgt_in(tgt_in), .status_in(status_in), .push_data(push_data),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata),
        .done(done), .busy(busy), .pc_out(pc_out), .status_out(status_out),
        .pull_data(pull_data), .sp_out(sp_out)
    );

    // page-one memory model, one cycle read latency, preset to ~index in reset
    logic [7:0] smem [256];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) smem[i] <= ~8'(i);
        end else if (mem_we) begin
            smem[mem_addr[7:0]] <= mem_wdata;
            if (mem_addr[15:8] != 8'h01) page_err <= page_err + 1;
        end
        mem_rdata <= smem[mem_addr[7:0]];
    end

    always @(negedge clk) begin
        if (done)   done_cnt++;
        if (mem_we) we_cnt++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [2:0] c);
        case (c)
            3'd1:    return "R3";
            3'd2:    return "R4";
            3'd3:    return "R6";
            3'd4:    return "R5";
            default: return "R7";
        endcase
    endfunction

    typedef struct packed {
        logic [2:0]  c;
        logic [15:0] pc;
        logic [15:0] tgt;
        logic [7:0]  st;
        logic [7:0]  dat;
        logic [15:0] e_pc;
        logic [7:0]  e_st;
        logic [7:0]  e_dat;
        logic [7:0]  e_sp;
        logic [3:0]  e_lat;
        logic [2:0]  mask;   // bit2 pc, bit1 status, bit0 pulled byte
        logic        mchk;
        logic [7:0]  maddr;
        logic [7:0]  mval;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{3'd5, 16'h0000, 16'h0000, 8'h00, 8'hA5, 16'h0000, 8'h00, 8'h00, 8'hFC, 4'd2, 3'b000, 1'b1, 8'hFD, 8'hA5},
        '{3'd6, 16'h0000, 16'h0000, 8'h00, 8'h00, 16'h0000, 8'h00, 8'hA5, 8'hFD, 4'd3, 3'b001, 1'b0, 8'h00, 8'h00},
        '{3'd1, 16'h1234, 16'hC000, 8'h00, 8'h00, 16'hC000, 8'h00, 8'h00, 8'hFB, 4'd3, 3'b100, 1'b1, 8'hFD, 8'h12},
        '{3'd2, 16'h0000, 16'h0000, 8'h00, 8'h00, 16'h1234, 8'h00, 8'h00, 8'hFD, 4'd4, 3'b100, 1'b1, 8'hFC, 8'h33},
        '{3'd4, 16'h8000, 16'hFFF0, 8'h81, 8'h00, 16'hFFF0, 8'hB5, 8'h00, 8'hFA, 4'd4, 3'b110, 1'b1, 8'hFB, 8'hB1},
        '{3'd3, 16'h0000, 16'h0000, 8'h00, 8'h00, 16'h8002, 8'hB1, 8'h00, 8'hFD, 4'd5, 3'b110, 1'b1, 8'hFC, 8'h02},
        '{3'd1, 16'h0000, 16'h4000, 8'h00, 8'h00, 16'h4000, 8'h00, 8'h00, 8'hFB, 4'd3, 3'b100, 1'b1, 8'hFC, 8'hFF},
        '{3'd2, 16'h0000, 16'h0000, 8'h00, 8'h00, 16'h0000, 8'h00, 8'h00, 8'hFD, 4'd4, 3'b100, 1'b1, 8'hFD, 8'hFF},
        '{3'd5, 16'h0000, 16'h0000, 8'h00, 8'h80, 16'h0000, 8'h00, 8'h00, 8'hFC, 4'd2, 3'b000, 1'b1, 8'hFD, 8'h80},
        '{3'd5, 16'h0000, 16'h0000, 8'h00, 8'h10, 16'h0000, 8'h00, 8'h00, 8'hFB, 4'd2, 3'b000, 1'b1, 8'hFC, 8'h10},
        '{3'd5, 16'h0000, 16'h0000, 8'h00, 8'h0C, 16'h0000, 8'h00, 8'h00, 8'hFA, 4'd2, 3'b000, 1'b1, 8'hFB, 8'h0C},
        '{3'd3, 16'h0000, 16'h0000, 8'h00, 8'h00, 16'h8010, 8'h2C, 8'h00, 8'hFD, 4'd5, 3'b110, 1'b0, 8'h00, 8'h00},
        '{3'd6, 16'h0000, 16'h0000, 8'h00, 8'h00, 16'h0000, 8'h00, 8'h01, 8'hFE, 4'd3, 3'b001, 1'b0, 8'h00, 8'h00},
        '{3'd6, 16'h0000, 16'h0000, 8'h00, 8'h00, 16'h0000, 8'h00, 8'h00, 8'hFF, 4'd3, 3'b001, 1'b0, 8'h00, 8'h00},
        '{3'd6, 16'h0000, 16'h0000, 8'h00, 8'h00, 16'h0000, 8'h00, 8'hFF, 8'h00, 4'd3, 3'b001, 1'b0, 8'h00, 8'h00},
        '{3'd5, 16'h0000, 16'h0000, 8'h00, 8'h3C, 16'h0000, 8'h00, 8'h00, 8'hFF, 4'd2, 3'b000, 1'b1, 8'h00, 8'h3C},
        '{3'd6, 16'h0000, 16'h0000, 8'h00, 8'h00, 16'h0000, 8'h00, 8'h3C, 8'h00, 4'd3, 3'b001, 1'b0, 8'h00, 8'h00}
    };

    task automatic run_cmd(input logic [2:0] c, input logic [15:0] pc, input logic [15:0] tgt,
                           input logic [7:0] st, input logic [7:0] dat, output int lat);
        @(negedge clk);
        cmd_valid = 1'b1; cmd = c; pc_in = pc; tgt_in = tgt; status_in = st; push_data = dat;
        @(negedge clk);
        cmd_valid = 1'b0; cmd = 3'd0;
        lat = 1;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int lat;
        int d0, w0;
        do_reset();
        // R2: reset state
        chk("R2", sp_out, 8'hFD);
        chk("R2", {done, busy}, 2'b00);
        chk("R2", {pc_out, status_out, pull_data}, 32'h0);

        for (int k = 0; k < NV; k++) begin
            run_cmd(VEC[k].c, VEC[k].pc, VEC[k].tgt, VEC[k].st, VEC[k].dat, lat);
            chk("R8", lat, VEC[k].e_lat);
            chk("R1", sp_out, VEC[k].e_sp);
            if (VEC[k].mask[2]) chk(req_of(VEC[k].c), pc_out, VEC[k].e_pc);
            if (VEC[k].mask[1]) chk(req_of(VEC[k].c), status_out, VEC[k].e_st);
            if (VEC[k].mask[0]) chk(req_of(VEC[k].c), pull_data, VEC[k].e_dat);
            if (VEC[k].mchk)    chk(req_of(VEC[k].c), smem[VEC[k].maddr], VEC[k].mval);
            @(negedge clk);
            chk("R8", done, 1'b0);
        end
        chk("R1", page_err, 0);

        // R9: stray push in the middle of a call
        do_reset();
        d0 = done_cnt;
        @(negedge clk);
        cmd_valid = 1'b1; cmd = 3'd1; pc_in = 16'h2000; tgt_in = 16'h3000;
        @(negedge clk);
        cmd = 3'd5; push_data = 8'h77;
        @(negedge clk);
        cmd_valid = 1'b0; cmd = 3'd0;
        @(negedge clk);
        chk("R9", done, 1'b1);
        chk("R9", pc_out, 16'h3000);
        chk("R9", sp_out, 8'hFB);
        repeat (4) @(negedge clk);
        chk("R9", sp_out, 8'hFB);
        chk("R9", done_cnt - d0, 1);
        chk("R9", smem[8'hFB], 8'h04);
        chk("R3", smem[8'hFC], 8'hFF);

        // R10 / R11: reserved codes while idle
        d0 = done_cnt; w0 = we_cnt;
        cmd_valid = 1'b1; cmd = 3'd7;
        @(negedge clk);
        cmd = 3'd0;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R10", busy, 1'b0);
        repeat (4) @(negedge clk);
        chk("R10", sp_out, 8'hFB);
        chk("R10", done_cnt - d0, 0);
        chk("R11", we_cnt - w0, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule